// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Status Logic

This block holds the timer status word of a processor core and runs the escalating watchdog sequence behind it. A periodic watchdog timeout pulse does not reset the chip on its first expiry. The first timeout arms the watchdog. The second timeout raises an interrupt flag. Only a timeout that arrives while both of those bits are still set asks for a reset, and the request carries the reset-type code chosen in the control logic. Software services the watchdog by writing ones to the status bits it wants to clear. Clearing a bit moves the sequence back to the earlier stage.

The same status word also logs decrementer and fixed-interval timer events. Each event has a sticky bit that is cleared by writing one to it. Each bit is gated with its own local enable and with the external interrupt enable to form an interrupt request. The watchdog flag is gated with the watchdog interrupt enable and the critical interrupt enable. The timebase, the decrementer counter and the interrupt controller are outside this block. They only drive its pulses and enables, or consume its requests.

Top module: `tmr_stat_wdog`

## Requirements
- R1: A watchdog timeout while the arm bit (status bit 0) is 0 sets the arm bit one cycle later and raises no reset request.
- R2: A watchdog timeout while the arm bit is 1 and the watchdog flag (status bit 1) is 0 sets the watchdog flag one cycle later.
- R3: The watchdog interrupt request is 1 exactly when the watchdog flag, the watchdog interrupt enable and the critical interrupt enable are all 1.
- R4: A watchdog timeout while the arm bit and the watchdog flag are both 1 and the reset code is nonzero gives a reset request one cycle later. The request lasts one cycle and carries that code on the reset-type output. The same code is loaded into the reset status field (status bits 3:2). The arm bit and the watchdog flag keep their values.
- R5: The same timeout with a reset code of 00 raises no request and changes no status bit.
- R6: After power-on reset the whole status word reads zero. The reset status field keeps its value until a write of ones to it clears it.
- R7: A decrementer event sets the decrementer bit (status bit 8). The decrementer interrupt request is 1 exactly when that bit, the decrementer interrupt enable and the external interrupt enable are all 1.
- R8: A fixed-interval event sets the fixed-interval bit (status bit 9). Its interrupt request is 1 exactly when that bit, the fixed-interval interrupt enable and the external interrupt enable are all 1.
- R9: A write clears exactly those status bits whose data bit is 1 and whose byte lane is enabled. Byte enable bit i covers data bits 8i+7 to 8i. Bits written with 0, and bits in disabled lanes, keep their values.
- R10: If a hardware set or load and a software clear hit the same bit in the same cycle, the bit ends up set (or loaded).
- R11: All status bits other than 0, 1, 3:2, 8 and 9 always read 0, and writes to them have no effect.
- R12: After the arm bit or the watchdog flag has been cleared, the next timeout resumes the sequence from the earlier stage: it sets the arm bit if that bit is 0, otherwise it sets the watchdog flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wd_tick_i | input | 1 | Watchdog timeout pulse |
| dec_evt_i | input | 1 | Decrementer event pulse |
| fit_evt_i | input | 1 | Fixed-interval event pulse |
| wr_en_i | input | 1 | Status write strobe |
| wr_be_i | input | DATA_W/8 | Byte enables of the write |
| wr_data_i | input | DATA_W | Write data; ones clear bits |
| crit_en_i | input | 1 | Global critical interrupt enable |
| ext_en_i | input | 1 | Global external interrupt enable |
| wd_int_en_i | input | 1 | Watchdog interrupt enable |
| dec_int_en_i | input | 1 | Decrementer interrupt enable |
| fit_int_en_i | input | 1 | Fixed-interval interrupt enable |
| rst_code_i | input | RC_W | Reset-control code; 0 means no reset |
| stat_o | output | DATA_W | Status word |
| wd_irq_o | output | 1 | Watchdog interrupt request |
| dec_irq_o | output | 1 | Decrementer interrupt request |
| fit_irq_o | output | 1 | Fixed-interval interrupt request |
| wd_rst_req_o | output | 1 | Watchdog reset request pulse |
| wd_rst_type_o | output | RC_W | Reset type sent with the request |

## Verification
Every status bit, the reset request and the reset type change on the clock edge that samples the stimulus. They are due one cycle after that stimulus. The three interrupt requests are combinational in the status bits and the enables. They therefore follow the updated status in that same cycle, and they follow any enable change with no added delay. The bench applies each stimulus half a period before an edge. It queues the expected word with the request values, and compares them one nanosecond after that edge, while the enables are still at the value the expectation was built with.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;

  localparam int unsigned ARM_BIT  = 0;
  localparam int unsigned WFLG_BIT = 1;
  localparam int unsigned RSTS_LO  = 2;
  localparam int unsigned DEC_BIT  = 8;
  localparam int unsigned FIT_BIT  = 9;
  localparam int unsigned IRQ_N    = 3;

  localparam int unsigned IRQ_WD  = 0;
  localparam int unsigned IRQ_DEC = 1;
  localparam int unsigned IRQ_FIT = 2;

  typedef enum logic [1:0] {
    WD_IDLE    = 2'b00,
    WD_FLAGREM = 2'b01,
    WD_ARMED   = 2'b10,
    WD_LIVE    = 2'b11
  } wd_stage_e;

endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  wr_en_i,
  input  logic [DATA_W/8-1:0]   wr_be_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     clr_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] lane_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{wr_be_i[g]}};
  end

  always_comb begin
    if (wr_en_i) clr_o = wr_data_i & lane_mask;
    else         clr_o = '0;
  end
endmodule

// File: rtl/tmr_sticky.sv
module tmr_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  // load beats clear so that no hardware event is lost
  always_comb begin
    if (ld_i) q_d = ld_val_i;
    else      q_d = q_r & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/tmr_wd_stage.sv
module tmr_wd_stage
  import tmr_stat_pkg::*;
#(
  parameter int unsigned RC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            arm_i,
  input  logic            flag_i,
  input  logic [RC_W-1:0] code_i,
  output logic            arm_set_o,
  output logic            flag_set_o,
  output logic            fire_o,
  output logic            rst_req_o,
  output logic [RC_W-1:0] rst_type_o
);
  wd_stage_e       stage;
  logic            req_d;
  logic [RC_W-1:0] type_d;

  assign stage = wd_stage_e'({arm_i, flag_i});

  always_comb begin
    arm_set_o  = 1'b0;
    flag_set_o = 1'b0;
    fire_o     = 1'b0;
    if (tick_i) begin
      unique case (stage)
        WD_IDLE, WD_FLAGREM: arm_set_o  = 1'b1;
        WD_ARMED:            flag_set_o = 1'b1;
        WD_LIVE:             fire_o     = |code_i;
        default:             fire_o     = 1'b0;
      endcase
    end
  end

  always_comb begin
    req_d  = fire_o;
    type_d = fire_o ? code_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_o  <= 1'b0;
      rst_type_o <= '0;
    end else begin
      rst_req_o  <= req_d;
      rst_type_o <= type_d;
    end
  end
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] glob_i,
  output logic [N-1:0] irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    assign irq_o[g] = flag_i[g] & en_i[g] & glob_i[g];
  end
endmodule

// File: rtl/tmr_stat_wdog.sv
module tmr_stat_wdog
  import tmr_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RC_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wd_tick_i,
  input  logic                dec_evt_i,
  input  logic                fit_evt_i,
  input  logic                wr_en_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                crit_en_i,
  input  logic                ext_en_i,
  input  logic                wd_int_en_i,
  input  logic                dec_int_en_i,
  input  logic                fit_int_en_i,
  input  logic [RC_W-1:0]     rst_code_i,
  output logic [DATA_W-1:0]   stat_o,
  output logic                wd_irq_o,
  output logic                dec_irq_o,
  output logic                fit_irq_o,
  output logic                wd_rst_req_o,
  output logic [RC_W-1:0]     wd_rst_type_o
);
  localparam int unsigned RSTS_HI = RSTS_LO + RC_W - 1;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DATA_W-1:0] clr;
  logic              arm_q, flag_q, dec_q, fit_q;
  logic [RC_W-1:0]   rsts_q;
  logic              arm_set, flag_set, fire;
  logic [IRQ_N-1:0]  irq_flag, irq_en, irq_glob, irq;

  tmr_wr_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_be_i  (wr_be_i),
    .wr_data_i(wr_data_i),
    .clr_o    (clr)
  );

  tmr_wd_stage #(.RC_W(RC_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (wd_tick_i),
    .arm_i     (arm_q),
    .flag_i    (flag_q),
    .code_i    (rst_code_i),
    .arm_set_o (arm_set),
    .flag_set_o(flag_set),
    .fire_o    (fire),
    .rst_req_o (wd_rst_req_o),
    .rst_type_o(wd_rst_type_o)
  );

  tmr_sticky #(.W(1)) u_arm (
    .clk(clk), .rst_n(rst_int_n), .ld_i(arm_set), .ld_val_i(1'b1),
    .clr_i(clr[ARM_BIT]), .q_o(arm_q)
  );

  tmr_sticky #(.W(1)) u_flag (
    .clk(clk), .rst_n(rst_int_n), .ld_i(flag_set), .ld_val_i(1'b1),
    .clr_i(clr[WFLG_BIT]), .q_o(flag_q)
  );

  tmr_sticky #(.W(RC_W)) u_rsts (
    .clk(clk), .rst_n(rst_int_n), .ld_i(fire), .ld_val_i(rst_code_i),
    .clr_i(clr[RSTS_HI:RSTS_LO]), .q_o(rsts_q)
  );

  tmr_sticky #(.W(1)) u_decf (
    .clk(clk), .rst_n(rst_int_n), .ld_i(dec_evt_i), .ld_val_i(1'b1),
    .clr_i(clr[DEC_BIT]), .q_o(dec_q)
  );

  tmr_sticky #(.W(1)) u_fitf (
    .clk(clk), .rst_n(rst_int_n), .ld_i(fit_evt_i), .ld_val_i(1'b1),
    .clr_i(clr[FIT_BIT]), .q_o(fit_q)
  );

  always_comb begin
    irq_flag           = '0;
    irq_en             = '0;
    irq_glob           = '0;
    irq_flag[IRQ_WD]   = flag_q;
    irq_en[IRQ_WD]     = wd_int_en_i;
    irq_glob[IRQ_WD]   = crit_en_i;
    irq_flag[IRQ_DEC]  = dec_q;
    irq_en[IRQ_DEC]    = dec_int_en_i;
    irq_glob[IRQ_DEC]  = ext_en_i;
    irq_flag[IRQ_FIT]  = fit_q;
    irq_en[IRQ_FIT]    = fit_int_en_i;
    irq_glob[IRQ_FIT]  = ext_en_i;
  end

  tmr_irq_gate #(.N(IRQ_N)) u_irq (
    .flag_i(irq_flag), .en_i(irq_en), .glob_i(irq_glob), .irq_o(irq)
  );

  assign wd_irq_o  = irq[IRQ_WD];
  assign dec_irq_o = irq[IRQ_DEC];
  assign fit_irq_o = irq[IRQ_FIT];

  // reserved bits stay zero (R11)
  always_comb begin
    stat_o                   = '0;
    stat_o[ARM_BIT]          = arm_q;
    stat_o[WFLG_BIT]         = flag_q;
    stat_o[RSTS_HI:RSTS_LO]  = rsts_q;
    stat_o[DEC_BIT]          = dec_q;
    stat_o[FIT_BIT]          = fit_q;
  end

  logic unused_clr_bits;
  always_comb begin
    logic [DATA_W-1:0] used;
    used                  = '0;
    used[ARM_BIT]         = 1'b1;
    used[WFLG_BIT]        = 1'b1;
    used[RSTS_HI:RSTS_LO] = '1;
    used[DEC_BIT]         = 1'b1;
    used[FIT_BIT]         = 1'b1;
    unused_clr_bits       = ^(clr & ~used);
  end
endmodule

// File: rtl/tmr_stat_chk.sv
module tmr_stat_chk
  import tmr_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RC_W   = 2
) (
  input logic                clk,
  input logic                rst_int_n,
  input logic                wd_tick_i,
  input logic                dec_evt_i,
  input logic                fit_evt_i,
  input logic                wr_en_i,
  input logic [DATA_W/8-1:0] wr_be_i,
  input logic                crit_en_i,
  input logic                wd_int_en_i,
  input logic [RC_W-1:0]     rst_code_i,
  input logic [DATA_W-1:0]   stat_o,
  input logic                wd_irq_o,
  input logic                wd_rst_req_o,
  input logic [RC_W-1:0]     wd_rst_type_o
);
  localparam int unsigned RSTS_HI = RSTS_LO + RC_W - 1;

  logic arm, flg, live;
  assign arm  = stat_o[ARM_BIT];
  assign flg  = stat_o[WFLG_BIT];
  assign live = wd_tick_i && arm && flg;

  assert_arm_stage_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wd_tick_i && !arm) |=> (stat_o[ARM_BIT] && !wd_rst_req_o));

  assert_flag_stage_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wd_tick_i && arm && !flg) |=> stat_o[WFLG_BIT]);

  assert_wd_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wd_irq_o == (flg && wd_int_en_i && crit_en_i));

  assert_reset_stage_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (live && rst_code_i != '0) |=>
      (wd_rst_req_o && wd_rst_type_o == $past(rst_code_i)
       && stat_o[RSTS_HI:RSTS_LO] == $past(rst_code_i)));

  assert_no_reset_code0_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (live && rst_code_i == '0) |=> !wd_rst_req_o);

  assert_rsts_hold_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!(wr_en_i && wr_be_i[0]) && !live) |=>
      stat_o[RSTS_HI:RSTS_LO] == $past(stat_o[RSTS_HI:RSTS_LO]));

  assert_dec_set_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_evt_i |=> stat_o[DEC_BIT]);

  assert_fit_set_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fit_evt_i |=> stat_o[FIT_BIT]);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(stat_o) == $countones({stat_o[FIT_BIT], stat_o[DEC_BIT],
                                      stat_o[RSTS_HI:RSTS_LO], flg, arm}));
endmodule

bind tmr_stat_wdog tmr_stat_chk #(.DATA_W(DATA_W), .RC_W(RC_W)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .wd_tick_i    (wd_tick_i),
  .dec_evt_i    (dec_evt_i),
  .fit_evt_i    (fit_evt_i),
  .wr_en_i      (wr_en_i),
  .wr_be_i      (wr_be_i),
  .crit_en_i    (crit_en_i),
  .wd_int_en_i  (wd_int_en_i),
  .rst_code_i   (rst_code_i),
  .stat_o       (stat_o),
  .wd_irq_o     (wd_irq_o),
  .wd_rst_req_o (wd_rst_req_o),
  .wd_rst_type_o(wd_rst_type_o)
);

// File: tb/tb_tmr_stat_wdog.sv
`timescale 1ns/1ps
module tb_tmr_stat_wdog;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wd_tick_i, dec_evt_i, fit_evt_i, wr_en_i;
  logic [3:0]  wr_be_i;
  logic [31:0] wr_data_i;
  logic        crit_en_i, ext_en_i, wd_int_en_i, dec_int_en_i, fit_int_en_i;
  logic [1:0]  rst_code_i;
  logic [31:0] stat_o;
  logic        wd_irq_o, dec_irq_o, fit_irq_o, wd_rst_req_o;
  logic [1:0]  wd_rst_type_o;

  always #2.5 clk = ~clk;

  tmr_stat_wdog dut (
    .clk(clk), .rst_n(rst_n), .wd_tick_i(wd_tick_i), .dec_evt_i(dec_evt_i),
    .fit_evt_i(fit_evt_i), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .crit_en_i(crit_en_i), .ext_en_i(ext_en_i),
    .wd_int_en_i(wd_int_en_i), .dec_int_en_i(dec_int_en_i),
    .fit_int_en_i(fit_int_en_i), .rst_code_i(rst_code_i), .stat_o(stat_o),
    .wd_irq_o(wd_irq_o), .dec_irq_o(dec_irq_o), .fit_irq_o(fit_irq_o),
    .wd_rst_req_o(wd_rst_req_o), .wd_rst_type_o(wd_rst_type_o)
  );

  typedef struct {
    logic [31:0] stat;
    logic [2:0]  irq;   // {fit, dec, wd}
    logic        req;
    logic [1:0]  rtype;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  // bench model state
  logic       m_arm = 0, m_flag = 0, m_dec = 0, m_fit = 0;
  logic [1:0] m_rs = 0;

  task automatic step(input logic tk, input logic de, input logic fe,
                      input logic we, input logic [3:0] be,
                      input logic [31:0] d, input string tag);
    logic [31:0] lm, clr;
    exp_t        e;
    logic        fire;
    for (int i = 0; i < 4; i++) lm[i*8 +: 8] = {8{be[i]}};
    clr  = we ? (d & lm) : 32'h0;
    fire = tk && m_arm && m_flag && (rst_code_i != 2'b00);
    if (fire) m_rs = rst_code_i; else m_rs = m_rs & ~clr[3:2];
    if (tk && m_arm && !m_flag) m_flag = 1; else m_flag = m_flag & ~clr[1];
    if (tk && !m_arm) m_arm = 1; else m_arm = m_arm & ~clr[0];
    m_dec = de ? 1'b1 : (m_dec & ~clr[8]);
    m_fit = fe ? 1'b1 : (m_fit & ~clr[9]);
    e.stat  = 32'h0;
    e.stat[0] = m_arm; e.stat[1] = m_flag; e.stat[3:2] = m_rs;
    e.stat[8] = m_dec; e.stat[9] = m_fit;
    e.irq   = {m_fit & fit_int_en_i & ext_en_i, m_dec & dec_int_en_i & ext_en_i,
               m_flag & wd_int_en_i & crit_en_i};
    e.req   = fire;
    e.rtype = fire ? rst_code_i : 2'b00;
    e.tag   = tag;
    wd_tick_i = tk; dec_evt_i = de; fit_evt_i = fe;
    wr_en_i = we; wr_be_i = be; wr_data_i = d;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 4'h0, 32'h0, tag);
  endtask

  // monitor: compares one nanosecond after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (stat_o !== e.stat || {fit_irq_o, dec_irq_o, wd_irq_o} !== e.irq ||
            wd_rst_req_o !== e.req || wd_rst_type_o !== e.rtype) begin
          n_err++;
          $display("FAIL %s: stat=%h irq=%b req=%b type=%0d expected stat=%h irq=%b req=%b type=%0d",
                   e.tag, stat_o, {fit_irq_o, dec_irq_o, wd_irq_o}, wd_rst_req_o,
                   wd_rst_type_o, e.stat, e.irq, e.req, e.rtype);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    wd_tick_i = 0; dec_evt_i = 0; fit_evt_i = 0; wr_en_i = 0;
    wr_be_i = 0; wr_data_i = 0;
    crit_en_i = 0; ext_en_i = 0; wd_int_en_i = 0; dec_int_en_i = 0;
    fit_int_en_i = 0; rst_code_i = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    idle("R6 R11 reset state all zero");
    step(1, 0, 0, 0, 4'h0, 32'h0, "R1 first timeout arms");
    wd_int_en_i = 1; crit_en_i = 1;
    step(1, 0, 0, 0, 4'h0, 32'h0, "R2 R3 second timeout flags and interrupts");
    crit_en_i = 0;
    idle("R3 critical enable off masks watchdog irq");
    crit_en_i = 1; rst_code_i = 2'b10;
    step(1, 0, 0, 0, 4'h0, 32'h0, "R4 third timeout requests reset code 2");
    idle("R4 R6 request is one cycle, status field holds");
    step(0, 0, 0, 1, 4'h0, 32'h0000_0002, "R9 disabled lane leaves flag");
    step(0, 0, 0, 1, 4'h1, 32'h0000_0002, "R9 R12 clear flag only");
    step(1, 0, 0, 0, 4'h0, 32'h0, "R12 timeout after flag clear sets flag");
    step(0, 0, 0, 1, 4'h1, 32'h0000_0003, "R9 clear arm and flag");
    step(1, 0, 0, 0, 4'h0, 32'h0, "R12 timeout after full clear re-arms");
    rst_code_i = 2'b00;
    step(1, 0, 0, 0, 4'h0, 32'h0, "R2 flag again");
    step(1, 0, 0, 0, 4'h0, 32'h0, "R5 code zero gives no reset");
    step(0, 0, 0, 1, 4'h1, 32'h0000_000C, "R6 write ones clears reset status");
    step(0, 0, 0, 1, 4'hF, 32'hFFFF_FC00, "R11 reserved write has no effect");
    dec_int_en_i = 1; ext_en_i = 1;
    step(0, 1, 0, 0, 4'h0, 32'h0, "R7 decrementer event and irq");
    ext_en_i = 0;
    idle("R7 external enable off masks decrementer irq");
    ext_en_i = 1; fit_int_en_i = 1;
    step(0, 0, 1, 1, 4'h2, 32'h0000_0200, "R8 R10 fixed-interval set beats clear");
    dec_int_en_i = 0;
    idle("R7 R8 local decrementer enable off");
    step(0, 0, 0, 1, 4'h2, 32'h0000_0300, "R7 R8 R9 clear both timer bits");
    step(0, 0, 0, 1, 4'h1, 32'h0000_0002, "R9 clear flag before race");
    step(1, 0, 0, 1, 4'h1, 32'h0000_0002, "R10 flag set beats same-cycle clear");
    rst_code_i = 2'b01;
    step(1, 0, 0, 1, 4'h1, 32'h0000_000C, "R4 R10 reset load beats clear code 1");
    idle("R4 arm and flag unchanged after request");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule